// File: doc/BRIEF.md
# Line-Aligned Pixel Enable Generator

This block produces the pixel-rate enable that paces video data out to a print engine. All of its logic runs on one fast clock. In internal-timing mode, that clock runs at four times the pixel rate and a programmable counter divides it down. Each active edge of the engine's line sync restarts the counter. The pixel grid of every line therefore starts a fixed, known number of fast cycles after that edge, so line placement resolves to a quarter pixel.

In engine-timing mode, the print engine supplies its own pixel clock. The block samples that clock into the fast domain and raises one pixel enable for each of its rising edges. No internal division takes place in this mode.

In both modes, one line-start pulse marks the first pixel enable after each active line-sync edge. The sync input has a selectable active polarity. The divide ratio is captured only at active sync edges, so a change takes effect at the start of a line.

Top module: `pixclk_align`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, `pix_en` and `line_start` are 0.
- R2: In internal-timing mode (`sync_mode`=0), before any active line-sync edge has arrived, `pix_en` pulses high for one cycle every 4 fast cycles, whatever `div_val` is set to.
- R3: In internal-timing mode, `hsync` is sampled through a two-stage synchronizer. When `hsync` changes to its active level at a point between two fast edges, the first following `pix_en` rises on the (D+3)-th fast rising edge after that change, where D is the captured divide ratio.
- R4: When `edge_fall`=0, the rising edge of `hsync` is active and a falling edge has no effect on pixel timing.
- R5: When `edge_fall`=1, the falling edge of `hsync` is active.
- R6: `div_val` is captured only at an active line-sync edge. Captured values of 0 or 1 act as 2. After the first enable of a line, `pix_en` repeats every D fast cycles.
- R7: `line_start` is a one-cycle pulse that coincides with the first `pix_en` after each active sync edge. It is never high at any other time, including before the first sync edge.
- R8: In engine-timing mode (`sync_mode`=1), each rising edge of `eng_clk` produces exactly one `pix_en` pulse, on the third fast rising edge after the change. When `eng_clk` is held still, no `pix_en` occurs.
- R9: In engine-timing mode, the first `pix_en` after an active `hsync` edge carries `line_start`, and later ones do not.
- R10: `pix_en` is never high on two consecutive fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, four times the pixel rate in internal-timing mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_clk | input | 1 | Pixel clock from the print engine, used in engine-timing mode |
| hsync | input | 1 | Line sync from the print engine (asynchronous) |
| sync_mode | input | 1 | 0 = divide the fast clock, 1 = follow eng_clk |
| edge_fall | input | 1 | 0 = rising hsync edge is active, 1 = falling |
| div_val | input | DIV_W | Divide ratio, captured at each active hsync edge |
| pix_en | output | 1 | One-cycle pixel enable |
| line_start | output | 1 | One-cycle pulse on the first pixel enable of a line |

## Verification
The no-back-to-back property assumes three things. `sync_mode` changes only while `eng_clk` is held low. `eng_clk` stays at each level for at least one fast cycle. `hsync` holds each level for several fast cycles. The bench changes `sync_mode` only with `eng_clk` low, keeps every engine-clock phase at two or more fast cycles, and holds each `hsync` level for tens of cycles. The bench drives every input on the falling fast edge and counts cycles to each output pulse against the D+3 and 3-cycle latencies. This exposes any extra or missing synchronizer stage.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_pol_e;
  typedef enum logic {MODE_DIVIDE = 1'b0, MODE_ENGINE = 1'b1} timing_mode_e;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n[0] = d;
    for (int i = 1; i < STAGES; i++) chain_n[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pa_edge.sv
module pa_edge
  import pa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_pol_e pol,
  output logic      pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign pulse = (pol == EDGE_FALL) ? (prev_q & ~lvl) : (lvl & ~prev_q);
endmodule

// File: rtl/pa_divider.sv
module pa_divider
  import pa_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int DIV_DEFAULT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  timing_mode_e     mode,
  input  logic             restart,
  input  logic             ext_tick,
  input  logic [DIV_W-1:0] div_in,
  output logic             pix_en,
  output logic             line_start,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] cnt_q
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT);

  logic [DIV_W-1:0] cnt_n, div_n, div_clamped;
  logic             pix_q, pix_n, ls_q, ls_n, first_q, first_n;

  assign div_clamped = (div_in < DIV_MIN) ? DIV_MIN : div_in;

  always_comb begin
    cnt_n   = cnt_q;
    div_n   = div_q;
    first_n = first_q;
    pix_n   = 1'b0;
    ls_n    = 1'b0;
    if (restart) begin
      cnt_n   = '0;
      div_n   = div_clamped;
      first_n = 1'b1;
    end else if (mode == MODE_ENGINE) begin
      cnt_n = '0;
      if (ext_tick) begin
        pix_n   = 1'b1;
        ls_n    = first_q;
        first_n = 1'b0;
      end
    end else if (cnt_q >= div_q - 1'b1) begin
      cnt_n   = '0;
      pix_n   = 1'b1;
      ls_n    = first_q;
      first_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_q   <= DIV_RST;
      first_q <= 1'b0;
      pix_q   <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      div_q   <= div_n;
      first_q <= first_n;
      pix_q   <= pix_n;
      ls_q    <= ls_n;
    end
  end

  assign pix_en     = pix_q;
  assign line_start = ls_q;
endmodule

// File: rtl/pixclk_align.sv
module pixclk_align
  import pa_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int DIV_DEFAULT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             eng_clk,
  input  logic             hsync,
  input  logic             sync_mode,
  input  logic             edge_fall,
  input  logic [DIV_W-1:0] div_val,
  output logic             pix_en,
  output logic             line_start
);
  logic             rst_sn;
  logic             hs_s, eng_s;
  logic             edge_det, eng_rise;
  logic [DIV_W-1:0] div_q, cnt_q;
  timing_mode_e     mode;
  edge_pol_e        pol;

  assign mode = timing_mode_e'(sync_mode);
  assign pol  = edge_pol_e'(edge_fall);

  // reset: asserted asynchronously, released on the clock
  pa_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk_fast), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  pa_sync #(.STAGES(SYNC_STAGES)) i_hs_sync (
    .clk(clk_fast), .rst_n(rst_sn), .d(hsync), .q(hs_s)
  );

  pa_sync #(.STAGES(SYNC_STAGES)) i_eng_sync (
    .clk(clk_fast), .rst_n(rst_sn), .d(eng_clk), .q(eng_s)
  );

  pa_edge i_hs_edge (
    .clk(clk_fast), .rst_n(rst_sn), .lvl(hs_s), .pol(pol), .pulse(edge_det)
  );

  pa_edge i_eng_edge (
    .clk(clk_fast), .rst_n(rst_sn), .lvl(eng_s), .pol(EDGE_RISE), .pulse(eng_rise)
  );

  pa_divider #(.DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)) i_div (
    .clk(clk_fast), .rst_n(rst_sn), .mode(mode), .restart(edge_det),
    .ext_tick(eng_rise), .div_in(div_val), .pix_en(pix_en),
    .line_start(line_start), .div_q(div_q), .cnt_q(cnt_q)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_mode,
  input logic             edge_det,
  input logic             pix_en,
  input logic             line_start,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] cnt_q
);
  // R10: enables are isolated single cycles
  a_r10_no_back2back: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  // R7: a line start always rides on a pixel enable
  a_r7_ls_with_pix: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_en);

  // R6: the captured ratio never falls below 2
  a_r6_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= DIV_W'(2));

  // R3: an active sync edge restarts the counter and suppresses output
  a_r3_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && !sync_mode) |=> (cnt_q == '0 && !pix_en && !line_start));

  // R8: no counting while following the engine clock
  a_r8_engine_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $past(sync_mode)) |-> cnt_q == '0);
endmodule

bind pixclk_align pa_checker #(.DIV_W(DIV_W)) i_chk (
  .clk(clk_fast), .rst_n(rst_sn), .sync_mode(sync_mode), .edge_det(edge_det),
  .pix_en(pix_en), .line_start(line_start), .div_q(div_q), .cnt_q(cnt_q)
);

// File: tb/test_pixclk_align.sv
module test_pixclk_align;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             eng_clk = 1'b0;
  logic             hsync = 1'b0;
  logic             sync_mode = 1'b0;
  logic             edge_fall = 1'b0;
  logic [DIV_W-1:0] div_val = 4'd9;
  logic             pix_en, line_start;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pixclk_align #(.DIV_W(DIV_W)) i_pixclk_align (
    .clk_fast(clk), .rst_n(rst_n), .eng_clk(eng_clk), .hsync(hsync),
    .sync_mode(sync_mode), .edge_fall(edge_fall), .div_val(div_val),
    .pix_en(pix_en), .line_start(line_start)
  );

  // polarity, divider input, expected period
  localparam int VECS [7][3] = '{
    '{0, 4, 4}, '{0, 7, 7}, '{1, 5, 5}, '{0, 0, 2},
    '{1, 1, 2}, '{0, 2, 2}, '{1, 15, 15}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count fast edges until the selected output is seen high
  task automatic wait_for(input bit want_ls, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!(want_ls ? line_start : pix_en) && n < 200);
  endtask

  task automatic prime_line(input bit pol, input int dv);
    edge_fall = pol;
    div_val   = DIV_W'(dv);
    hsync     = pol;
    cycles(40);
    hsync = ~pol;
  endtask

  initial begin
    int n;
    int ls_seen;
    cycles(3);
    check(pix_en == 0 && line_start == 0, "R1", pix_en, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(pix_en == 0 && line_start == 0, "R1", line_start, 0);
    cycles(4);

    // R2: default ratio before any sync edge, div_val is ignored
    wait_for(0, n);
    wait_for(0, n);
    check(n == 4, "R2", n, 4);
    check(line_start == 0, "R7", line_start, 0);
    wait_for(0, n);
    check(n == 4, "R2", n, 4);

    // vector table: R3 latency, R5 polarity, R6 period and clamp
    for (int v = 0; v < 7; v++) begin
      prime_line(VECS[v][0][0], VECS[v][1]);
      wait_for(1, n);
      check(n == VECS[v][2] + 3, "R3", n, VECS[v][2] + 3);
      check(pix_en == 1, "R7", pix_en, 1);
      if (VECS[v][0] == 1) check(n == VECS[v][2] + 3, "R5", n, VECS[v][2] + 3);
      @(posedge clk); @(negedge clk);
      check(line_start == 0 && pix_en == 0, "R7", line_start, 0);
      n = 1;
      while (!pix_en && n < 200) begin @(posedge clk); @(negedge clk); n++; end
      check(n == VECS[v][2], "R6", n, VECS[v][2]);
      check(line_start == 0, "R7", line_start, 1'b0);
    end

    // R4: inactive edge leaves the phase untouched
    prime_line(1'b0, 6);
    wait_for(1, n);
    hsync = 1'b0;
    ls_seen = 0;
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
      if (line_start) ls_seen++;
    end while (!pix_en && n < 200);
    check(n == 6, "R4", n, 6);
    wait_for(0, n);
    check(n == 6 && !line_start && ls_seen == 0, "R4", n, 6);

    // R8 / R9: engine clock mode
    eng_clk = 1'b0;
    sync_mode = 1'b1;
    edge_fall = 1'b0;
    hsync = 1'b0;
    cycles(40);
    hsync = 1'b1;
    cycles(6);
    eng_clk = 1'b1;
    wait_for(0, n);
    check(n == 3, "R8", n, 3);
    check(line_start == 1, "R9", line_start, 1);
    cycles(2);
    eng_clk = 1'b0;
    cycles(3);
    eng_clk = 1'b1;
    wait_for(0, n);
    check(n == 3, "R8", n, 3);
    check(line_start == 0, "R9", line_start, 0);
    cycles(2);
    eng_clk = 1'b0;
    cycles(4);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (pix_en) n++;
    end
    check(n == 0, "R8", n, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    done = 1'b1;
    $finish;
  end

  // R10 also observed at the ports
  logic prev_pix = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done && prev_pix && pix_en) check(1'b0, "R10", 1, 0);
    prev_pix <= pix_en;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule